// File: doc/BRIEF.md
# Ephemeral Scrambling Key Manager

This block holds the key and nonce that feed a memory scrambler. It keeps them current through software-triggered renewals. Out of reset both values are all-zero. The memory can be used at once with that fixed key, because scrambling is never bypassed and only the key value changes. When software writes a 1 to the renew bit, the block toggles a request flag. A two-flop synchronizer carries that flag into the key provider's clock domain, where it becomes a level request. The request stays high until the provider pulses its acknowledge. The acknowledge returns the same way, as a toggle, and the local side captures the key, nonce and seed-valid flag directly from the provider's bus. This is safe because the provider holds those values steady for at least 62 of its own clock cycles after the acknowledge.

While a renewal is outstanding, the key-valid status is low and every memory access is answered with an error. Software can clear a lock bit so that later renew writes are refused until reset. A 4-bit multibit escalation input guards the key. Any code other than the Off value wipes the key, nonce and seed flag to zero on the next clock edge. It also drops key-valid, refuses further renewals, discards any key that arrives later and makes every access fail until reset.

Top module: `skey_mgr`

## Requirements
- R1: After reset, key_o and nonce_o are zero, key_valid_o, seed_valid_o and prov_req_o are 0, renew_unlocked_o is 1, and an access (acc_req_i=1) gets acc_err_o=0.
- R2: A renew write (renew_we_i=1 with renew_wdata_i=1) accepted while idle raises prov_req_o. The request stays high until the cycle after prov_ack_i is seen high, then drops. A renew write with renew_wdata_i=0 launches nothing.
- R3: key_valid_o is 0 from the clock edge that accepts a renew write until the key is captured, and 1 after a capture.
- R4: The key and nonce presented with the acknowledge pulse appear on key_o and nonce_o. They keep that value after the provider changes its bus, once the 62-cycle stability window has passed.
- R5: seed_valid_o equals the seed-valid flag presented with the acknowledge, both when it is 1 and when it is 0.
- R6: acc_err_o is 1 whenever acc_req_i is 1 while a renewal is pending, and 0 when an access is made with a settled key and no escalation.
- R7: A renew write made while a request is pending is ignored: each completed renewal raises prov_req_o exactly once.
- R8: Writing 0 to the lock bit (lock_we_i=1, lock_wdata_i=0) clears renew_unlocked_o. Writing 1 later does not set it again, and renew writes are then ignored until reset.
- R9: If esc_i differs from the Off code 4'b0101 for even one cycle, then at the next edge key_o, nonce_o, seed_valid_o and key_valid_o become 0 and stay 0 until reset. Every access gets acc_err_o=1, renew writes start no request, and a late acknowledge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_i | input | 1 | Local synchronous active-high reset |
| clk_prov_i | input | 1 | Key provider clock |
| rst_prov_i | input | 1 | Provider-domain synchronous active-high reset |
| esc_i | input | 4 | Multibit escalation code, Off = 4'b0101 |
| renew_we_i | input | 1 | Write strobe of the renew control bit |
| renew_wdata_i | input | 1 | Renew bit value written |
| lock_we_i | input | 1 | Write strobe of the renew lock bit |
| lock_wdata_i | input | 1 | Lock bit value written (0 locks) |
| acc_req_i | input | 1 | Memory access in this cycle |
| acc_err_o | output | 1 | Error response for the current access |
| key_valid_o | output | 1 | Status: a fresh key has been captured |
| seed_valid_o | output | 1 | Status: captured key came from provisioned seeds |
| renew_unlocked_o | output | 1 | Renew writes are still permitted |
| key_o | output | 128 | Scrambling key to the datapath |
| nonce_o | output | 64 | Scrambling nonce to the datapath |
| prov_req_o | output | 1 | Key request to the provider (provider domain) |
| prov_ack_i | input | 1 | Single-cycle acknowledge from the provider |
| prov_key_i | input | 128 | Key returned by the provider |
| prov_nonce_i | input | 64 | Nonce returned by the provider |
| prov_seed_valid_i | input | 1 | Seed-valid flag returned by the provider |

## Verification
The bench scrambles the provider bus as soon as the 62-cycle window ends. A design that captured late, or that re-sampled the bus after the window, would show the scrambled key. It writes a second renew while a request is pending and counts provider request edges. A design that queued or re-toggled the request would make an extra request or leave the handshake stuck. Escalation is raised for one cycle in the middle of a pending renewal, and the acknowledge is delivered afterwards. A design that wiped only once would then take the late key and report it as valid. A second escalation uses a different non-Off code to catch a decoder that matched only one value.

// File: rtl/skey_pkg.sv
package skey_pkg;
    localparam int KEY_W       = 128;
    localparam int NONCE_W     = 64;
    localparam int ESC_W       = 4;
    localparam int SYNC_STAGES = 2;
    localparam logic [ESC_W-1:0] ESC_OFF = 4'b0101;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DEAD = 2'b10
    } kst_e;

    typedef struct packed {
        logic [KEY_W-1:0]   key;
        logic [NONCE_W-1:0] nonce;
        logic               seed_ok;
    } kmat_t;

    // Any code other than the single Off pattern counts as escalation.
    function automatic logic esc_active(input logic [ESC_W-1:0] code);
        return code != ESC_OFF;
    endfunction
endpackage

// File: rtl/skey_tgl_sync.sv
module skey_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tgl_i,
    output logic pulse_o
);
    logic [STAGES-1:0] chain_q;
    logic              seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], tgl_i};
            seen_q  <= chain_q[STAGES-1];
        end
    end

    // One destination-domain pulse per toggle of the source flag.
    assign pulse_o = chain_q[STAGES-1] ^ seen_q;
endmodule

// File: rtl/skey_prov_port.sv
module skey_prov_port
    import skey_pkg::*;
(
    input  logic clk_prov_i,
    input  logic rst_prov_i,
    input  logic req_tgl_i,
    input  logic ack_i,
    output logic req_o,
    output logic ack_tgl_o
);
    logic req_pulse;
    logic req_q;
    logic ack_tgl_q;

    skey_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i  (clk_prov_i),
        .rst_i  (rst_prov_i),
        .tgl_i  (req_tgl_i),
        .pulse_o(req_pulse)
    );

    always_ff @(posedge clk_prov_i) begin
        if (rst_prov_i) begin
            req_q     <= 1'b0;
            ack_tgl_q <= 1'b0;
        end else if (req_q && ack_i) begin
            req_q     <= 1'b0;
            ack_tgl_q <= ~ack_tgl_q;
        end else if (req_pulse) begin
            req_q     <= 1'b1;
        end
    end

    assign req_o     = req_q;
    assign ack_tgl_o = ack_tgl_q;

    AST_REQ_HELD: assert property (@(posedge clk_prov_i) disable iff (rst_prov_i)
        (req_q && !ack_i) |=> req_q); // R2
    AST_REQ_DROPS: assert property (@(posedge clk_prov_i) disable iff (rst_prov_i)
        (req_q && ack_i) |=> !req_q); // R2
endmodule

// File: rtl/skey_ctrl_fsm.sv
module skey_ctrl_fsm
    import skey_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ESC_W-1:0] esc_i,
    input  logic             renew_we_i,
    input  logic             renew_wdata_i,
    input  logic             lock_we_i,
    input  logic             lock_wdata_i,
    input  logic             ack_pulse_i,
    input  kmat_t            mat_i,
    output logic             req_tgl_o,
    output kst_e             state_o,
    output kmat_t            mat_o,
    output logic             key_valid_o,
    output logic             unlocked_o
);
    kst_e  state_q;
    kmat_t mat_q;
    logic  kv_q;
    logic  unlocked_q;
    logic  req_tgl_q;
    logic  esc_hit;
    logic  renew_hit;

    assign esc_hit   = esc_active(esc_i);
    assign renew_hit = renew_we_i && renew_wdata_i && unlocked_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_IDLE;
            mat_q      <= '0;
            kv_q       <= 1'b0;
            unlocked_q <= 1'b1;
            req_tgl_q  <= 1'b0;
        end else begin
            if (lock_we_i && !lock_wdata_i) begin
                unlocked_q <= 1'b0;
            end
            if (esc_hit || state_q == ST_DEAD) begin
                // Wipe and stay wiped until reset.
                state_q <= ST_DEAD;
                mat_q   <= '0;
                kv_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (renew_hit) begin
                            state_q   <= ST_WAIT;
                            kv_q      <= 1'b0;
                            req_tgl_q <= ~req_tgl_q;
                        end
                    end
                    ST_WAIT: begin
                        // Provider bus is stable here: sample it directly.
                        if (ack_pulse_i) begin
                            mat_q   <= mat_i;
                            kv_q    <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_DEAD;
                endcase
            end
        end
    end

    assign req_tgl_o   = req_tgl_q;
    assign state_o     = state_q;
    assign mat_o       = mat_q;
    assign key_valid_o = kv_q;
    assign unlocked_o  = unlocked_q;

    AST_WAIT_NOT_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_WAIT) |-> !kv_q); // R3
    AST_CAPTURE_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_WAIT && ack_pulse_i && !esc_hit) |=> (kv_q && mat_q == $past(mat_i))); // R4
    AST_PENDING_NO_RETOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_WAIT) |=> $stable(req_tgl_q)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        !unlocked_q |=> !unlocked_q); // R8
    AST_DEAD_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DEAD) |=> (state_q == ST_DEAD && mat_q == '0 && !kv_q)); // R9
    AST_ESC_WIPES: assert property (@(posedge clk_i) disable iff (rst_i)
        esc_hit |=> (mat_q == '0 && !kv_q)); // R9
endmodule

// File: rtl/skey_mgr.sv
module skey_mgr
    import skey_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               clk_prov_i,
    input  logic               rst_prov_i,
    input  logic [ESC_W-1:0]   esc_i,
    input  logic               renew_we_i,
    input  logic               renew_wdata_i,
    input  logic               lock_we_i,
    input  logic               lock_wdata_i,
    input  logic               acc_req_i,
    output logic               acc_err_o,
    output logic               key_valid_o,
    output logic               seed_valid_o,
    output logic               renew_unlocked_o,
    output logic [KEY_W-1:0]   key_o,
    output logic [NONCE_W-1:0] nonce_o,
    output logic               prov_req_o,
    input  logic               prov_ack_i,
    input  logic [KEY_W-1:0]   prov_key_i,
    input  logic [NONCE_W-1:0] prov_nonce_i,
    input  logic               prov_seed_valid_i
);
    logic  req_tgl;
    logic  ack_tgl;
    logic  ack_pulse;
    kst_e  state;
    kmat_t mat_in;
    kmat_t mat_cur;

    assign mat_in = '{key: prov_key_i, nonce: prov_nonce_i, seed_ok: prov_seed_valid_i};

    skey_ctrl_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .esc_i        (esc_i),
        .renew_we_i   (renew_we_i),
        .renew_wdata_i(renew_wdata_i),
        .lock_we_i    (lock_we_i),
        .lock_wdata_i (lock_wdata_i),
        .ack_pulse_i  (ack_pulse),
        .mat_i        (mat_in),
        .req_tgl_o    (req_tgl),
        .state_o      (state),
        .mat_o        (mat_cur),
        .key_valid_o  (key_valid_o),
        .unlocked_o   (renew_unlocked_o)
    );

    skey_prov_port u_prov (
        .clk_prov_i(clk_prov_i),
        .rst_prov_i(rst_prov_i),
        .req_tgl_i (req_tgl),
        .ack_i     (prov_ack_i),
        .req_o     (prov_req_o),
        .ack_tgl_o (ack_tgl)
    );

    skey_tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tgl_i  (ack_tgl),
        .pulse_o(ack_pulse)
    );

    // Accesses fail unless a key is settled and no escalation was seen.
    assign acc_err_o    = acc_req_i && (state != ST_IDLE);
    assign key_o        = mat_cur.key;
    assign nonce_o      = mat_cur.nonce;
    assign seed_valid_o = mat_cur.seed_ok;

    AST_NO_ERR_WITHOUT_ACC: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_req_i |-> !acc_err_o); // R6
    AST_VALID_KEY_SERVES: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_req_i && key_valid_o) |-> !acc_err_o); // R6
endmodule

// File: tb/skey_mgr_tb.sv
module skey_mgr_tb_top;
    logic         clk_i = 1'b0;
    logic         clk_prov_i = 1'b0;
    logic         rst_i = 1'b1;
    logic         rst_prov_i = 1'b1;
    logic [3:0]   esc_i = 4'b0101;
    logic         renew_we_i = 1'b0;
    logic         renew_wdata_i = 1'b0;
    logic         lock_we_i = 1'b0;
    logic         lock_wdata_i = 1'b1;
    logic         acc_req_i = 1'b0;
    logic         acc_err_o;
    logic         key_valid_o;
    logic         seed_valid_o;
    logic         renew_unlocked_o;
    logic [127:0] key_o;
    logic [63:0]  nonce_o;
    logic         prov_req_o;
    logic         prov_ack_i = 1'b0;
    logic [127:0] prov_key_i = '0;
    logic [63:0]  prov_nonce_i = '0;
    logic         prov_seed_valid_i = 1'b0;

    int errors = 0;
    int checks = 0;
    int req_count = 0;
    logic req_prev = 1'b0;

    always #10 clk_i = ~clk_i;
    always #15 clk_prov_i = ~clk_prov_i;

    skey_mgr dut_i (.*);

    always @(posedge clk_prov_i) begin
        if (prov_req_o && !req_prev) req_count <= req_count + 1;
        req_prev <= prov_req_o;
    end

    typedef struct packed {
        logic [127:0] key;
        logic [63:0]  nonce;
        logic         seed;
        logic         dup;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{ {4{32'hA5C3_1E07}}, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0 },
        '{ {4{32'h5EED_0000}}, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b1 },
        '{ {2{64'h1357_9BDF_0246_8ACE}}, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b1 },
        '{ 128'h1, 64'h8000_0000_0000_0000, 1'b0, 1'b0 }
    };

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        rst_prov_i = 1'b1;
        repeat (4) @(negedge clk_prov_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        rst_prov_i = 1'b0;
        @(negedge clk_i);
    endtask

    task automatic write_renew(input logic val);
        @(negedge clk_i);
        renew_we_i = 1'b1;
        renew_wdata_i = val;
        @(negedge clk_i);
        renew_we_i = 1'b0;
        renew_wdata_i = 1'b0;
    endtask

    task automatic write_lock(input logic val);
        @(negedge clk_i);
        lock_we_i = 1'b1;
        lock_wdata_i = val;
        @(negedge clk_i);
        lock_we_i = 1'b0;
        lock_wdata_i = 1'b1;
    endtask

    // Provider model: answers a request, holds data 62 cycles, then scrambles it.
    task automatic provide(input logic [127:0] k, input logic [63:0] n, input logic s);
        for (int w = 0; w < 200 && !prov_req_o; w++) @(negedge clk_prov_i);
        check("R2", "request raised", 128'(prov_req_o), 128'(1));
        prov_ack_i = 1'b1;
        prov_key_i = k;
        prov_nonce_i = n;
        prov_seed_valid_i = s;
        @(negedge clk_prov_i);
        prov_ack_i = 1'b0;
        @(negedge clk_prov_i);
        check("R2", "request dropped after ack", 128'(prov_req_o), 128'(0));
        repeat (61) @(negedge clk_prov_i);
        prov_key_i = ~k;
        prov_nonce_i = ~n;
        prov_seed_valid_i = ~s;
        repeat (5) @(negedge clk_prov_i);
    endtask

    task automatic check_access(input string req, input logic exp);
        acc_req_i = 1'b1;
        #1;
        check(req, "access error", 128'(acc_err_o), 128'(exp));
        acc_req_i = 1'b0;
    endtask

    task automatic check_reset_state();
        check("R1", "key zero", key_o, 128'(0));
        check("R1", "nonce zero", 128'(nonce_o), 128'(0));
        check("R1", "key_valid low", 128'(key_valid_o), 128'(0));
        check("R1", "seed_valid low", 128'(seed_valid_o), 128'(0));
        check("R1", "unlocked", 128'(renew_unlocked_o), 128'(1));
        check("R1", "no request", 128'(prov_req_o), 128'(0));
        check_access("R1", 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        check_reset_state();

        // Vector table: one renewal per entry
        for (int i = 0; i < 4; i++) begin
            write_renew(1'b1);
            check("R3", "key_valid low while pending", 128'(key_valid_o), 128'(0));
            check_access("R6", 1'b1);
            if (VECS[i].dup) write_renew(1'b1); // R7: second write ignored
            provide(VECS[i].key, VECS[i].nonce, VECS[i].seed);
            @(negedge clk_i);
            check("R3", "key_valid after capture", 128'(key_valid_o), 128'(1));
            check("R4", "key held past window", key_o, VECS[i].key);
            check("R4", "nonce held past window", 128'(nonce_o), 128'(VECS[i].nonce));
            check("R5", "seed_valid captured", 128'(seed_valid_o), 128'(VECS[i].seed));
            check_access("R6", 1'b0);
            repeat (20) @(negedge clk_i);
            check("R7", "one request per renewal", 128'(req_count), 128'(i + 1));
        end

        // R2: writing 0 to the renew bit launches nothing
        write_renew(1'b0);
        repeat (30) @(negedge clk_i);
        check("R2", "zero write no request", 128'(req_count), 128'(4));
        check("R2", "zero write keeps valid", 128'(key_valid_o), 128'(1));

        // R8: lock
        write_lock(1'b0);
        check("R8", "lock cleared", 128'(renew_unlocked_o), 128'(0));
        write_lock(1'b1);
        check("R8", "lock not re-opened", 128'(renew_unlocked_o), 128'(0));
        write_renew(1'b1);
        repeat (30) @(negedge clk_i);
        check("R8", "locked renew no request", 128'(req_count), 128'(4));
        check("R8", "locked renew keeps valid", 128'(key_valid_o), 128'(1));
        check("R8", "locked renew keeps key", key_o, VECS[3].key);

        // R9: escalation in the middle of a pending renewal
        do_reset();
        check_reset_state();
        write_renew(1'b1);
        esc_i = 4'b0000;
        @(negedge clk_i);
        esc_i = 4'b0101;
        check("R9", "key wiped", key_o, 128'(0));
        check("R9", "key_valid low", 128'(key_valid_o), 128'(0));
        check_access("R9", 1'b1);
        provide(VECS[0].key, VECS[0].nonce, 1'b1);
        repeat (20) @(negedge clk_i);
        check("R9", "late key dropped", key_o, 128'(0));
        check("R9", "late nonce dropped", 128'(nonce_o), 128'(0));
        check("R9", "valid stays low", 128'(key_valid_o), 128'(0));
        check("R9", "seed stays low", 128'(seed_valid_o), 128'(0));
        write_renew(1'b1);
        repeat (30) @(negedge clk_i);
        check("R9", "renew refused", 128'(req_count), 128'(5));
        check_access("R9", 1'b1);

        // R9: escalation with another non-Off code after a settled key
        do_reset();
        write_renew(1'b1);
        provide(VECS[2].key, VECS[2].nonce, 1'b1);
        @(negedge clk_i);
        check("R4", "key before escalation", key_o, VECS[2].key);
        esc_i = 4'b1010;
        @(negedge clk_i);
        esc_i = 4'b0101;
        check("R9", "key wiped by 1010", key_o, 128'(0));
        check("R9", "nonce wiped by 1010", 128'(nonce_o), 128'(0));
        check("R9", "seed wiped by 1010", 128'(seed_valid_o), 128'(0));
        check("R9", "valid dropped by 1010", 128'(key_valid_o), 128'(0));
        repeat (5) @(negedge clk_i);
        check_access("R9", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule